// File: doc/BRIEF.md
# DRAM Strobe Decoder

This block is the control front end of a 1M x 16 asynchronous DRAM, rebuilt as synchronous logic. A fast system clock samples every strobe pin. The two byte column strobes are merged into one internal column strobe, which follows the first byte strobe to fall and the last one to rise. Each row-strobe cycle is sorted into one of four kinds: a normal access, a row-only refresh, a column-before-row refresh, or a self refresh. A row-strobe low that is held long enough escalates a column-before-row refresh into self refresh.

The block holds the internal row pointer that supplies the refresh row. It reports the row actually used by each cycle, and it drives one output enable per byte lane. A storage array model or a tester reads the cycle code, the row and the enables to decide what the array does.

Every output shows the pins as captured two rising clock edges earlier. The first edge registers the pins and the second updates the decoded state.

Top module: `dram_strobe_decoder`

## Requirements
- R1: All outputs reflect pin values captured two rising edges earlier. After reset, cyc_type is 0 (idle), and row_used, refresh_active, cas_active, lane_oe_lo and lane_oe_hi are all 0.
- R2: cas_active is 1 when lcas_n or ucas_n was low. It is 0 only when both were high.
- R3: The first low sample of ras_n, taken when the merged column strobe was already active in the sample before, starts a column-before-row refresh (cyc_type 3). In that cycle row_used takes the internal refresh pointer and the addr pins are ignored.
- R4: Any other first low sample of ras_n latches addr from that same sample into row_used. The cycle is coded 2 (row-only refresh) until the merged column strobe is active during that row-strobe low, and 1 (access) from then on, including the first sample itself.
- R5: lane_oe_lo is 1 only in an access cycle (code 1) when lcas_n was low, oe_n low and we_n high. lane_oe_hi follows the same rule using ucas_n.
- R6: While cyc_type is 3 or 4, both lane enables stay 0 whatever oe_n and we_n do.
- R7: A column-before-row refresh whose ras_n stays low for more than SELF_ENTRY_CYC consecutive samples becomes self refresh (code 4).
- R8: Self refresh ends, back to code 0, only after SELF_EXIT_CYC consecutive high samples of ras_n. A shorter high stretch leaves the code at 4 and restarts the count.
- R9: The refresh pointer steps by one when a column-before-row refresh ends on ras_n high, or when self refresh exits. It wraps from 1023 to 0.
- R10: refresh_active is 1 whenever cyc_type is not 0, because every kind of cycle refreshes a row. A high ras_n sample ends an access, row-only or column-before-row cycle, and the code returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe pin, active low |
| lcas_n | input | 1 | Lower byte column strobe, active low |
| ucas_n | input | 1 | Upper byte column strobe, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| addr | input | 10 | Multiplexed address pins |
| cyc_type | output | 3 | 0 idle, 1 access, 2 row-only, 3 column-before-row, 4 self refresh |
| row_used | output | 10 | Row chosen by the current or last cycle |
| refresh_active | output | 1 | A row is being refreshed |
| cas_active | output | 1 | Merged internal column strobe |
| lane_oe_lo | output | 1 | Drive enable for data bits 7..0 |
| lane_oe_hi | output | 1 | Drive enable for data bits 15..8 |

## Verification
Two functions meet in the sample where ras_n first goes low. There, the strobe merge must already have settled for the refresh-or-access decision to be right. The bench lowers one byte strobe a sample ahead of ras_n and the other together with it, which must give a column-before-row refresh that takes the pointer row. It also lowers a column strobe in the very sample ras_n falls, which must give an access that latches addr. A reference model, fed the same pin stream, judges both cases and the random traffic that surrounds them, field by field.

// File: rtl/dram_dec_pkg.sv
// Shared cycle encoding for the DRAM strobe decoder.
// Assumes consumers compare cycle codes as 3-bit values.
package dram_dec_pkg;
    typedef enum logic [2:0] {
        CYC_IDLE     = 3'd0,
        CYC_ACCESS   = 3'd1,
        CYC_RAS_ONLY = 3'd2,
        CYC_CBR      = 3'd3,
        CYC_SELF     = 3'd4
    } cyc_e;
endpackage

// File: rtl/dram_pin_sampler.sv
// Registers every strobe and address pin once on the system clock.
// Assumes pins are already synchronous or slow compared with clk.
// Reset leaves all strobes inactive (high) and the address at zero.
module dram_pin_sampler #(
    parameter int ROW_W = 10,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic [LANES-1:0] cas_n,
    input  logic             oe_n,
    input  logic             we_n,
    input  logic [ROW_W-1:0] addr,
    output logic             ras_q,
    output logic [LANES-1:0] cas_q,
    output logic             oe_q,
    output logic             we_q,
    output logic [ROW_W-1:0] addr_q
);
    // Capture the pin set, strobes idle high under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q  <= 1'b1;
            cas_q  <= '1;
            oe_q   <= 1'b1;
            we_q   <= 1'b1;
            addr_q <= '0;
        end else begin
            ras_q  <= ras_n;
            cas_q  <= cas_n;
            oe_q   <= oe_n;
            we_q   <= we_n;
            addr_q <= addr;
        end
    end
endmodule

// File: rtl/dram_cas_merge.sv
// Combines the byte column strobes into one internal column strobe.
// It is active as soon as any lane is low and inactive only when all lanes
// are high. Also keeps the previous sample's strobe for refresh detection.
module dram_cas_merge #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] cas_q,
    output logic             cas_now,
    output logic             cas_prev
);
    logic [LANES-1:0] lane_act;

    // Per-lane activity, one gate per byte lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_act[g] = ~cas_q[g];
    end

    // First lane down raises the strobe, last lane up drops it.
    always_comb cas_now = |lane_act;

    // Remember the strobe of the previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) cas_prev <= 1'b0;
        else        cas_prev <= cas_now;
    end
endmodule

// File: rtl/dram_cycle_fsm.sv
// Classifies each row-strobe cycle and tracks the self refresh windows.
// Assumes ras_q is the sampled row strobe, cas_now the merged strobe of the
// same sample and cas_prev the merged strobe of the sample before it.
// SELF_EXIT_CYC must be at least 1.
module dram_cycle_fsm
    import dram_dec_pkg::*;
#(
    parameter int SELF_ENTRY_CYC = 40,
    parameter int SELF_EXIT_CYC  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_q,
    input  logic cas_now,
    input  logic cas_prev,
    output cyc_e state,
    output cyc_e nxt,
    output logic take_ctr,
    output logic take_addr,
    output logic ctr_adv
);
    localparam int MAXC  = (SELF_ENTRY_CYC > SELF_EXIT_CYC) ? SELF_ENTRY_CYC : SELF_EXIT_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] ENTRY_LIM = CNT_W'(SELF_ENTRY_CYC);
    localparam logic [CNT_W-1:0] EXIT_LIM  = CNT_W'(SELF_EXIT_CYC - 1);

    logic [CNT_W-1:0] cnt, cnt_nxt;

    // Next-state and window-count decision for the current sample.
    always_comb begin
        nxt       = state;
        cnt_nxt   = cnt;
        take_ctr  = 1'b0;
        take_addr = 1'b0;
        ctr_adv   = 1'b0;
        unique case (state)
            CYC_IDLE: begin
                if (!ras_q) begin
                    if (cas_prev) begin
                        nxt      = CYC_CBR;
                        take_ctr = 1'b1;
                        cnt_nxt  = CNT_W'(1);
                    end else begin
                        nxt       = cas_now ? CYC_ACCESS : CYC_RAS_ONLY;
                        take_addr = 1'b1;
                    end
                end
            end
            CYC_ACCESS: begin
                if (ras_q) nxt = CYC_IDLE;
            end
            CYC_RAS_ONLY: begin
                if (ras_q)        nxt = CYC_IDLE;
                else if (cas_now) nxt = CYC_ACCESS;
            end
            CYC_CBR: begin
                if (ras_q) begin
                    nxt     = CYC_IDLE;
                    ctr_adv = 1'b1;
                    cnt_nxt = '0;
                end else if (cnt == ENTRY_LIM) begin
                    nxt     = CYC_SELF;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt + CNT_W'(1);
                end
            end
            CYC_SELF: begin
                if (ras_q) begin
                    if (cnt == EXIT_LIM) begin
                        nxt     = CYC_IDLE;
                        ctr_adv = 1'b1;
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt + CNT_W'(1);
                    end
                end else begin
                    cnt_nxt = '0;
                end
            end
            default: begin
                nxt     = CYC_IDLE;
                cnt_nxt = '0;
            end
        endcase
    end

    // State and window counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CYC_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end
endmodule

// File: rtl/dram_refresh_ctr.sv
// Internal refresh row pointer. It advances by one per completed refresh
// that used it and wraps naturally at 2**ROW_W.
module dram_refresh_ctr #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [ROW_W-1:0] ptr
);
    // Step the pointer on each completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr <= '0;
        else if (adv) ptr <= ptr + ROW_W'(1);
    end
endmodule

// File: rtl/dram_lane_oe.sv
// Per-byte-lane output enables. A lane drives only during an access cycle
// with its own column strobe low, output enable low and write enable high.
// Assumes in_access already implies the row strobe is low.
module dram_lane_oe #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_access,
    input  logic [LANES-1:0] cas_q,
    input  logic             oe_q,
    input  logic             we_q,
    output logic [LANES-1:0] lane_oe
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Register one lane's drive enable.
        always_ff @(posedge clk) begin
            if (!rst_n) lane_oe[g] <= 1'b0;
            else        lane_oe[g] <= in_access & ~cas_q[g] & ~oe_q & we_q;
        end
    end
endmodule

// File: rtl/dram_strobe_decoder.sv
// Control front end of a 1M x 16 asynchronous DRAM in synchronous form.
// Samples the pins, merges the byte column strobes, classifies the cycle,
// selects the row (pins or refresh pointer) and drives lane enables.
// Assumes the clock is fast enough to see every strobe edge; all outputs
// lag the pins by two rising edges.
module dram_strobe_decoder
    import dram_dec_pkg::*;
#(
    parameter int ROW_W          = 10,
    parameter int SELF_ENTRY_CYC = 40,
    parameter int SELF_EXIT_CYC  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic             lcas_n,
    input  logic             ucas_n,
    input  logic             oe_n,
    input  logic             we_n,
    input  logic [ROW_W-1:0] addr,
    output logic [2:0]       cyc_type,
    output logic [ROW_W-1:0] row_used,
    output logic             refresh_active,
    output logic             cas_active,
    output logic             lane_oe_lo,
    output logic             lane_oe_hi
);
    localparam int LANES = 2;

    logic             ras_q, oe_q, we_q;
    logic [LANES-1:0] cas_q;
    logic [ROW_W-1:0] addr_q;
    logic             cas_now, cas_prev;
    cyc_e             state, nxt;
    logic             take_ctr, take_addr, ctr_adv;
    logic [ROW_W-1:0] refresh_ptr;
    logic [LANES-1:0] lane_oe;

    dram_pin_sampler #(.ROW_W(ROW_W), .LANES(LANES)) u_sampler (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n({ucas_n, lcas_n}),
        .oe_n(oe_n), .we_n(we_n), .addr(addr), .ras_q(ras_q), .cas_q(cas_q),
        .oe_q(oe_q), .we_q(we_q), .addr_q(addr_q)
    );

    dram_cas_merge #(.LANES(LANES)) u_merge (
        .clk(clk), .rst_n(rst_n), .cas_q(cas_q), .cas_now(cas_now), .cas_prev(cas_prev)
    );

    dram_cycle_fsm #(.SELF_ENTRY_CYC(SELF_ENTRY_CYC), .SELF_EXIT_CYC(SELF_EXIT_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ras_q(ras_q), .cas_now(cas_now), .cas_prev(cas_prev),
        .state(state), .nxt(nxt), .take_ctr(take_ctr), .take_addr(take_addr), .ctr_adv(ctr_adv)
    );

    dram_refresh_ctr #(.ROW_W(ROW_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .adv(ctr_adv), .ptr(refresh_ptr)
    );

    dram_lane_oe #(.LANES(LANES)) u_oe (
        .clk(clk), .rst_n(rst_n), .in_access(nxt == CYC_ACCESS), .cas_q(cas_q),
        .oe_q(oe_q), .we_q(we_q), .lane_oe(lane_oe)
    );

    // Latch the row at the start of each cycle from pins or refresh pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)         row_used <= '0;
        else if (take_ctr)  row_used <= refresh_ptr;
        else if (take_addr) row_used <= addr_q;
    end

    assign cyc_type       = state;
    assign refresh_active = (state != CYC_IDLE);
    assign cas_active     = cas_prev;
    assign lane_oe_lo     = lane_oe[0];
    assign lane_oe_hi     = lane_oe[1];
endmodule

// File: rtl/dram_strobe_decoder_chk.sv
// Property checker for the DRAM strobe decoder, attached by bind.
module dram_strobe_decoder_chk
    import dram_dec_pkg::*;
#(
    parameter int ROW_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cyc_type,
    input logic [ROW_W-1:0] row_used,
    input logic [ROW_W-1:0] refresh_ptr,
    input logic             lane_oe_lo,
    input logic             lane_oe_hi
);
    assert_oe_only_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_oe_lo || lane_oe_hi) |-> cyc_type == CYC_ACCESS);

    assert_quiet_in_refresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == CYC_CBR || cyc_type == CYC_SELF) |-> (!lane_oe_lo && !lane_oe_hi));

    assert_cbr_takes_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == CYC_CBR && $past(cyc_type) == CYC_IDLE) |-> row_used == refresh_ptr);

    assert_self_after_cbr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_type == CYC_SELF) |-> $past(cyc_type) == CYC_CBR);

    assert_ptr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cyc_type) == CYC_CBR || $past(cyc_type) == CYC_SELF) && cyc_type == CYC_IDLE)
        |-> refresh_ptr == ROW_W'($past(refresh_ptr) + ROW_W'(1)));

    assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type != CYC_IDLE) |=> (cyc_type == CYC_IDLE || $stable(refresh_ptr)));
endmodule

bind dram_strobe_decoder dram_strobe_decoder_chk #(.ROW_W(ROW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cyc_type(cyc_type), .row_used(row_used),
    .refresh_ptr(refresh_ptr), .lane_oe_lo(lane_oe_lo), .lane_oe_hi(lane_oe_hi)
);

// File: tb/dram_strobe_decoder_tb.sv
// Bench: directed corner cases plus seeded random pin traffic, each output
// compared with a reference model built from the requirements.
module dram_strobe_decoder_tb;
    localparam int RW    = 10;
    localparam int ENTRY = 40;
    localparam int EXITC = 12;
    localparam int I_IDLE = 0, I_ACC = 1, I_RO = 2, I_CBR = 3, I_SELF = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [RW-1:0] addr = '0;
    logic [2:0]    cyc_type;
    logic [RW-1:0] row_used;
    logic          refresh_active, cas_active, lane_oe_lo, lane_oe_hi;

    int checks = 0;
    int failures = 0;
    int m_state, m_cnt, m_ctr, m_cas_prev, m_row;
    int e_state, e_row, e_ref, e_cas, e_lo, e_hi;
    int r_ras, r_l, r_u;

    always #4 clk = ~clk;

    dram_strobe_decoder #(.ROW_W(RW), .SELF_ENTRY_CYC(ENTRY), .SELF_EXIT_CYC(EXITC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
        .oe_n(oe_n), .we_n(we_n), .addr(addr), .cyc_type(cyc_type), .row_used(row_used),
        .refresh_active(refresh_active), .cas_active(cas_active),
        .lane_oe_lo(lane_oe_lo), .lane_oe_hi(lane_oe_hi)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model: consume one sampled pin vector.
    task automatic model_step(input int r, input int l, input int u, input int o, input int w, input int a);
        int cas, nx;
        cas = (l == 0 || u == 0) ? 1 : 0;
        nx  = m_state;
        case (m_state)
            I_IDLE: if (r == 0) begin
                if (m_cas_prev == 1) begin nx = I_CBR; m_row = m_ctr; m_cnt = 1; end
                else begin nx = cas ? I_ACC : I_RO; m_row = a; end
            end
            I_ACC: if (r == 1) nx = I_IDLE;
            I_RO:  if (r == 1) nx = I_IDLE; else if (cas == 1) nx = I_ACC;
            I_CBR: if (r == 1) begin nx = I_IDLE; m_ctr = (m_ctr + 1) % 1024; m_cnt = 0; end
                   else if (m_cnt == ENTRY) begin nx = I_SELF; m_cnt = 0; end
                   else m_cnt++;
            I_SELF: if (r == 1) begin
                        if (m_cnt == EXITC - 1) begin nx = I_IDLE; m_ctr = (m_ctr + 1) % 1024; m_cnt = 0; end
                        else m_cnt++;
                    end else m_cnt = 0;
            default: nx = I_IDLE;
        endcase
        e_lo = (nx == I_ACC && l == 0 && o == 0 && w == 1) ? 1 : 0;
        e_hi = (nx == I_ACC && u == 0 && o == 0 && w == 1) ? 1 : 0;
        e_cas = cas;
        m_cas_prev = cas;
        m_state = nx;
        e_state = nx;
        e_row = m_row;
        e_ref = (nx != I_IDLE) ? 1 : 0;
    endtask

    // Drive one vector at a falling edge, check the previous vector's result.
    task automatic step(input int r, input int l, input int u, input int o, input int w,
                        input int a, input string tag);
        ras_n = r[0]; lcas_n = l[0]; ucas_n = u[0]; oe_n = o[0]; we_n = w[0]; addr = RW'(a);
        @(negedge clk);
        chk(tag, "cyc_type", int'(cyc_type), e_state);
        chk(tag, "row_used", int'(row_used), e_row);
        chk(tag, "refresh_active", int'(refresh_active), e_ref);
        chk(tag, "cas_active", int'(cas_active), e_cas);
        chk(tag, "lane_oe_lo", int'(lane_oe_lo), e_lo);
        chk(tag, "lane_oe_hi", int'(lane_oe_hi), e_hi);
        model_step(r, l, u, o, w, a);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, 1, 1, 1, 1, 0, tag);
    endtask

    // One column-before-row refresh with a junk address on the pins.
    task automatic cbr(input string tag);
        step(1, 0, 1, 1, 1, 777, tag);
        step(0, 0, 1, 0, 1, 555, tag);
        step(1, 0, 1, 0, 1, 333, tag);
        step(1, 1, 1, 1, 1, 0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired checks=%0d", checks);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        m_state = I_IDLE; m_cnt = 0; m_ctr = 0; m_cas_prev = 0; m_row = 0;
        e_state = 0; e_row = 0; e_ref = 0; e_cas = 0; e_lo = 0; e_hi = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        chk("R1", "reset cyc_type", int'(cyc_type), 0);
        chk("R1", "reset row_used", int'(row_used), 0);
        chk("R1", "reset lanes", int'({lane_oe_hi, lane_oe_lo, cas_active, refresh_active}), 0);
        idle(3, "R1");

        // R4/R5: read, lower lane only, then both lanes, then a write
        step(0, 1, 1, 0, 1, 300, "R4");
        step(0, 0, 1, 0, 1, 11, "R4");
        step(0, 0, 0, 0, 1, 12, "R5");
        step(0, 1, 0, 0, 1, 13, "R2");
        step(0, 0, 0, 0, 0, 14, "R5");
        step(0, 0, 0, 1, 1, 14, "R5");
        step(1, 1, 1, 1, 1, 0, "R10");
        idle(2, "R10");
        // R4: RAS-only refresh, CAS never falls
        step(0, 1, 1, 0, 1, 512, "R4");
        step(0, 1, 1, 0, 1, 1, "R4");
        step(1, 1, 1, 1, 1, 0, "R10");
        idle(2, "R4");
        // Coincidence: CAS falls in the very RAS fall sample -> access
        step(0, 1, 0, 0, 1, 99, "R4");
        step(0, 1, 0, 0, 1, 98, "R5");
        step(1, 1, 1, 1, 1, 0, "R4");
        idle(2, "R4");
        // Coincidence: upper strobe one sample ahead, lower with RAS -> CBR
        step(1, 1, 0, 0, 1, 200, "R2");
        step(0, 0, 0, 0, 1, 201, "R3");
        step(0, 0, 0, 0, 1, 202, "R6");
        step(1, 1, 1, 1, 1, 0, "R9");
        idle(2, "R9");
        cbr("R3");
        cbr("R9");
        idle(2, "R9");

        // R7/R8: self refresh entry, short exit pulse, real exit
        step(1, 0, 0, 1, 1, 0, "R7");
        for (int i = 0; i < ENTRY + 6; i++) step(0, 0, 0, 0, 1, i, "R7");
        for (int i = 0; i < EXITC - 2; i++) step(1, 0, 0, 0, 1, 0, "R8");
        step(0, 0, 0, 0, 1, 0, "R8");
        step(0, 1, 1, 0, 1, 0, "R6");
        for (int i = 0; i < EXITC + 2; i++) step(1, 1, 1, 1, 1, 0, "R8");
        idle(2, "R8");
        // CBR released exactly at the entry limit stays a plain CBR
        step(1, 0, 1, 1, 1, 0, "R7");
        for (int i = 0; i < ENTRY; i++) step(0, 0, 1, 1, 1, 0, "R7");
        step(1, 1, 1, 1, 1, 0, "R7");
        idle(2, "R7");

        // R9: run the pointer to 1023 and wrap
        while (m_ctr != 1022) cbr("R9");
        cbr("R9");
        cbr("R9");
        cbr("R9");
        idle(2, "R9");

        // Random traffic against the model
        r_ras = 1; r_l = 1; r_u = 1;
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 23) == 0) r_ras = 1 - r_ras;
            if ($urandom_range(0, 3) == 0) r_l = 1 - r_l;
            if ($urandom_range(0, 3) == 0) r_u = 1 - r_u;
            step(r_ras, r_l, r_u, int'($urandom_range(0, 1)), int'($urandom_range(0, 3) != 0),
                 int'($urandom_range(0, 1023)), "R10");
        end
        idle(EXITC + 4, "R8");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule